// File: doc/BRIEF.md
# Receive Ring Write DMA

This engine moves incoming packets from a valid/ready stream straight into memory buffers through a 32-bit Wishbone master. Software describes its empty buffers in a circular ring of two-word descriptors held in memory, programs the ring's base address, and hands buffers to the engine by pulsing a count. For every packet the engine walks to the next descriptor, reads the buffer address and capacity, and writes the packet beats into the buffer. It then stores the received byte length in the descriptor and gives the buffer back.

A small FIFO sits between the stream and the bus, so that stream beats keep arriving while a memory write waits for its acknowledge. No packet is staged on chip. A packet that does not fit is cut at the buffer's capacity, and its surplus beats are swallowed. The count of buffers the engine still holds is always visible, so software can work out how many have been filled.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset the held count is 0, the bus is idle (wb_cyc low) and s_ready is low.
- R2: A push of N (push_valid high with push_count = N) adds N to held_count on the next edge. A completed buffer subtracts 1. When both happen in the same cycle the result is held_count + N - 1.
- R3: While held_count is 0 the engine does not fetch a descriptor and keeps s_ready low.
- R4: Ring entry i sits at cfg_ring_base + 8*i. Word 0 holds the buffer byte address. Word 1 holds the capacity in bytes, and its two low bits are ignored. After the last entry (RING_ENTRIES, a power of two) the engine returns to entry 0.
- R5: Stored beat k of a packet is written as a full 32-bit word (wb_sel all ones) to buffer address + 4*k, in arrival order.
- R6: On the beat with s_last high, s_bytes gives the valid bytes: 0 means 4, and 1 to 3 mean that many. Every earlier beat counts as 4 bytes.
- R7: Beats beyond capacity/4 words are accepted and discarded up to and including s_last. Buffer words past capacity are never written.
- R8: After the data, the engine writes the stored byte length (zero-extended) into word 1 of the descriptor. The buffer is released on the acknowledge of that write.
- R9: A bus request keeps wb_stb, wb_adr, wb_we and wb_dat_o steady until wb_ack. Only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_base | input | 32 | Byte address of ring entry 0 |
| push_valid | input | 1 | Hand buffers to the engine this cycle |
| push_count | input | CNT_W | Number of buffers handed over |
| held_count | output | CNT_W | Buffers currently owned by the engine |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted |
| s_data | input | 32 | Stream beat data |
| s_last | input | 1 | Final beat of packet |
| s_bytes | input | 2 | Valid bytes on final beat (0 = 4) |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | 32 | Bus byte address |
| wb_dat_o | output | 32 | Bus write data |
| wb_sel | output | 4 | Bus byte selects |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack | input | 1 | Bus acknowledge |

## Verification
The bench builds the engine with a four-entry ring, a two-deep FIFO and an eight-bit length field. Ring wrap and FIFO-full backpressure then happen many times in a short run. With these sizes every packet length from one to six beats can be crossed with every last-beat byte count and with capacities of zero, two words, an unaligned value and a full sixteen words. This covers truncation at each boundary. A phase in which the memory model pushes a new buffer on the very acknowledge that releases one drives the coinciding push-and-release case repeatedly.

// File: rtl/rx_ring_dma.sv
`timescale 1ns/1ps
module rx_ring_dma #(
  parameter int RING_ENTRIES = 8,
  parameter int FIFO_DEPTH   = 8,
  parameter int LEN_W        = 16,
  localparam int IDX_W = $clog2(RING_ENTRIES),
  localparam int CNT_W = IDX_W + 1,
  localparam int FP_W  = $clog2(FIFO_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_ring_base,
  input  logic             push_valid,
  input  logic [CNT_W-1:0] push_count,
  output logic [CNT_W-1:0] held_count,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [31:0]      s_data,
  input  logic             s_last,
  input  logic [1:0]       s_bytes,
  output logic             wb_cyc,
  output logic             wb_stb,
  output logic             wb_we,
  output logic [31:0]      wb_adr,
  output logic [31:0]      wb_dat_o,
  output logic [3:0]       wb_sel,
  input  logic [31:0]      wb_dat_i,
  input  logic             wb_ack
);

  typedef enum logic [2:0] {IDLE, GET_ADR, GET_CAP, MOVE, PUT_LEN} st_t;
  st_t st;

  logic [IDX_W-1:0] slot;
  logic [31:0]      buf_adr;
  logic [LEN_W-3:0] cap_w, in_w, out_w;
  logic [LEN_W-1:0] len;
  logic             got_last;
  logic [31:0]      fifo [FIFO_DEPTH];
  logic [FP_W:0]    wp, rp;

  wire [FP_W:0] fcnt  = wp - rp;
  wire          full  = fcnt == FIFO_DEPTH[FP_W:0];
  wire          empty = wp == rp;
  wire [31:0]   desc_adr = cfg_ring_base + (32'(slot) << 3);

  assign s_ready = (st == MOVE) && !got_last && !full;
  wire   take    = s_valid && s_ready;
  wire   keep    = take && (in_w != cap_w);
  wire [2:0] tail = (s_bytes == 2'd0) ? 3'd4 : {1'b0, s_bytes};
  wire   done    = (st == PUT_LEN) && wb_ack;

  assign wb_stb = wb_cyc;
  assign wb_sel = 4'hF;

  always_comb begin
    wb_cyc   = 1'b0;
    wb_we    = 1'b0;
    wb_adr   = desc_adr;
    wb_dat_o = fifo[rp[FP_W-1:0]];
    case (st)
      GET_ADR: wb_cyc = 1'b1;
      GET_CAP: begin
        wb_cyc = 1'b1;
        wb_adr = desc_adr + 32'd4;
      end
      MOVE: begin
        wb_cyc = !empty;
        wb_we  = 1'b1;
        wb_adr = buf_adr + (32'(out_w) << 2);
      end
      PUT_LEN: begin
        wb_cyc   = 1'b1;
        wb_we    = 1'b1;
        wb_adr   = desc_adr + 32'd4;
        wb_dat_o = 32'(len);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk)
    if (keep) fifo[wp[FP_W-1:0]] <= s_data;

  always_ff @(posedge clk) begin
    if (!rst_n) held_count <= '0;
    else held_count <= held_count + (push_valid ? push_count : '0) - CNT_W'(done);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      slot     <= '0;
      buf_adr  <= '0;
      cap_w    <= '0;
      in_w     <= '0;
      out_w    <= '0;
      len      <= '0;
      got_last <= 1'b0;
      wp       <= '0;
      rp       <= '0;
    end else begin
      case (st)
        IDLE: if (held_count != '0) st <= GET_ADR;
        GET_ADR: if (wb_ack) begin
          buf_adr <= wb_dat_i;
          st      <= GET_CAP;
        end
        GET_CAP: if (wb_ack) begin
          cap_w    <= wb_dat_i[LEN_W-1:2];
          in_w     <= '0;
          out_w    <= '0;
          len      <= '0;
          got_last <= 1'b0;
          st       <= MOVE;
        end
        MOVE: begin
          if (keep) begin
            wp   <= wp + 1'b1;
            in_w <= in_w + 1'b1;
            len  <= len + (s_last ? LEN_W'(tail) : LEN_W'(4));
          end
          if (take && s_last) got_last <= 1'b1;
          if (wb_ack) begin
            rp    <= rp + 1'b1;
            out_w <= out_w + 1'b1;
          end
          if (got_last && empty) st <= PUT_LEN;
        end
        PUT_LEN: if (wb_ack) begin
          slot <= slot + 1'b1;
          st   <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

module rx_ring_dma_chk #(
  parameter int RING_ENTRIES = 8,
  localparam int CNT_W = $clog2(RING_ENTRIES) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic [CNT_W-1:0] push_count,
  input logic [CNT_W-1:0] held_count,
  input logic             s_ready,
  input logic             wb_stb,
  input logic             wb_we,
  input logic [31:0]      wb_adr,
  input logic [31:0]      wb_dat_o,
  input logic             wb_ack
);
  logic past_ok;
  always_ff @(posedge clk)
    if (!rst_n) past_ok <= 1'b0;
    else past_ok <= 1'b1;

  a_r3_no_ready_without_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> held_count != '0);

  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && wb_stb && !wb_ack |=> wb_stb && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_o));

  a_r2_push_adds: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && push_valid && !(wb_ack && wb_we) |=> held_count == $past(held_count) + $past(push_count));

  a_r8_release_on_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !push_valid && !(wb_ack && wb_we) |=> held_count == $past(held_count));

  a_r2_release_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !push_valid |=> (held_count == $past(held_count)) || (held_count == $past(held_count) - CNT_W'(1)));
endmodule

bind rx_ring_dma rx_ring_dma_chk #(.RING_ENTRIES(RING_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_count(push_count),
  .held_count(held_count), .s_ready(s_ready), .wb_stb(wb_stb), .wb_we(wb_we),
  .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_ack(wb_ack));

// File: tb/sim_rx_ring_dma.sv
`timescale 1ns/1ps
module sim_rx_ring_dma;
  localparam int CLK_PERIOD = 10;
  localparam int RE = 4;
  localparam int CW = 3;
  localparam int BUF0 = 32'h100;

  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_ring_base = 32'h0;
  logic push_valid = 0;
  logic [CW-1:0] push_count = 0;
  logic [CW-1:0] held_count;
  logic s_valid = 0, s_ready, s_last = 0;
  logic [31:0] s_data = 0;
  logic [1:0] s_bytes = 0;
  logic wb_cyc, wb_stb, wb_we, wb_ack = 0;
  logic [31:0] wb_adr, wb_dat_o, wb_dat_i = 0;
  logic [3:0] wb_sel;

  rx_ring_dma #(.RING_ENTRIES(RE), .FIFO_DEPTH(2), .LEN_W(8)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] mem [128];
  int exp_held = 0, comps = 0, push_req = 0, cyc_n = 0;
  int waitc = 0, lat = 0, txn = 0;
  bit coincide = 0, run = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc_n++;
    if (cyc_n > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc_n);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (run) chk(held_count == CW'(exp_held), "R2 held_count", held_count, exp_held);
    push_valid = 0;
    if (wb_ack) wb_ack = 0;
    else if (wb_stb) begin
      if (waitc >= lat) begin
        if (wb_we) begin
          chk(wb_sel == 4'hF, "R5 sel", wb_sel, 4'hF);
          if (wb_adr[31:2] < 128) mem[wb_adr[8:2]] = wb_dat_o;
          if (wb_adr < BUF0 && wb_adr[2]) begin
            comps++;
            exp_held--;
            if (coincide) begin
              push_valid = 1; push_count = 1; exp_held++;
            end
          end
        end else wb_dat_i = (wb_adr[31:2] < 128) ? mem[wb_adr[8:2]] : 32'hX;
        wb_ack = 1; waitc = 0; txn++; lat = txn % 3;
      end else waitc++;
    end
    if (push_req > 0) begin
      push_count = push_valid ? push_count + CW'(push_req) : CW'(push_req);
      push_valid = 1; exp_held += push_req; push_req = 0;
    end
  end

  int cap_of [RE];

  task automatic prep(int slot, int cap);
    mem[slot*2]   = BUF0 + slot*64;
    mem[slot*2+1] = cap;
    cap_of[slot]  = cap;
    for (int i = 0; i < 16; i++) mem[64 + slot*16 + i] = 32'hEE00_0000 | (slot << 8) | i;
  endtask

  int pkt_no = 0;
  bit have_credit = 0;

  task automatic run_pkt(int cap, int words, int nb, bit pushnext);
    int slot, capw, stored, exp_len, target, t;
    bit r;
    slot = pkt_no % RE;
    if (!have_credit) begin prep(slot, cap); push_req = 1; end
    if (pushnext) prep((slot + 1) % RE, 64);
    coincide = pushnext;
    target = comps + 1;
    for (int i = 0; i < words; i++) begin
      if ((i + pkt_no) % 3 == 0) begin s_valid = 0; @(negedge clk); end
      s_valid = 1;
      s_data  = {pkt_no[15:0], i[15:0]};
      s_last  = (i == words - 1);
      s_bytes = s_last ? nb[1:0] : 2'd0;
      t = 0;
      do begin
        #1 r = s_ready;
        @(negedge clk);
        t++;
      end while (!r && t < 2000);
    end
    s_valid = 0; s_last = 0;
    t = 0;
    while (comps < target && t < 2000) begin @(negedge clk); t++; end
    capw   = cap_of[slot] >> 2;
    stored = (words < capw) ? words : capw;
    exp_len = (words <= capw) ? 4*(words-1) + ((nb == 0) ? 4 : nb) : 4*capw;
    chk(mem[slot*2+1] == exp_len, "R8/R6/R7 length", mem[slot*2+1], exp_len);
    for (int i = 0; i < 16; i++) begin
      if (i < stored)
        chk(mem[64+slot*16+i] == {pkt_no[15:0], i[15:0]}, "R5/R4 data", mem[64+slot*16+i], {pkt_no[15:0], i[15:0]});
      else
        chk(mem[64+slot*16+i] == (32'hEE00_0000 | (slot << 8) | i), "R7 untouched", mem[64+slot*16+i], 32'hEE00_0000 | (slot << 8) | i);
    end
    have_credit = pushnext;
    pkt_no++;
  endtask

  initial begin
    int caps [4];
    caps = '{0, 8, 13, 64};
    for (int i = 0; i < 128; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(held_count == 0, "R1 held", held_count, 0);
    chk(wb_cyc == 0, "R1 bus idle", wb_cyc, 0);
    chk(s_ready == 0, "R1 ready", s_ready, 0);
    run = 1;
    s_valid = 1; s_data = 32'h1234; s_last = 1;
    for (int i = 0; i < 10; i++) begin
      #1;
      chk(s_ready == 0, "R3 ready without buffer", s_ready, 0);
      chk(wb_cyc == 0, "R3 no fetch without buffer", wb_cyc, 0);
      @(negedge clk);
    end
    s_valid = 0; s_last = 0;
    foreach (caps[c])
      for (int w = 1; w <= 6; w++)
        for (int nb = 0; nb < 4; nb++)
          run_pkt(caps[c], w, nb, 0);
    for (int k = 0; k < 8; k++) run_pkt(64, (k % 5) + 1, k % 4, k < 7);
    repeat (5) @(negedge clk);
    chk(held_count == 0, "R2 final held", held_count, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule